// File: doc/BRIEF.md
# Three-Phase Switching Error Detector

This block watches the three half-bridge legs of a motor drive stage and reports when a switch node fails to follow its gate commands. For each leg it takes the commanded high-side and low-side gate states and the digitised level of the switch node. While exactly one side of a leg is on, it compares the node level with the level that side should produce. The node should be high when the upper switch is on and low when the lower switch is on.

The node needs time to slew, so any mismatch is ignored for a programmable number of clock cycles after a side turns on. The window length `win_len` is counted in clock cycles, and the count starts again whenever the side's command rises. Errors are reported per side and per leg. There is a combined any-leg flag and a separate high-side summary that feeds the desaturation fault logic outside this block.

Top module: `bridge_fault_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, every error output is low.
- R2: A leg's `hs_err` bit is high in the cycle after a clock edge when that edge sampled all of these: the high command on, the low command off, the node low (expected level 1), and the high command on at more than `win_len` consecutive edges, counting that edge.
- R3: A leg's `ls_err` bit is high in the cycle after a clock edge when that edge sampled all of these: the low command on, the high command off, the node high (expected level 0), and the low command on at more than `win_len` consecutive edges, counting that edge.
- R4: A mismatch is blanked for the first `win_len` edges at which a side is sampled on, so no error is raised during that time.
- R5: A command that drops before its window has elapsed never produces an error, whatever the node does.
- R6: With both commands of a leg on, or both off, that leg reports no error.
- R7: `ph_err[i]` is the OR of `hs_err[i]` and `ls_err[i]`. `any_err` is the OR of all `ph_err` bits.
- R8: `desat_hint` is high exactly when any leg's `hs_err` bit is high.
- R9: With `win_len` = 0 the comparison applies from the first edge at which a side is sampled on.
- R10: The on-time count saturates at its maximum. A side held on for longer than that stays checked, even with `win_len` at its maximum.
- R11: Each new rising edge of a command restarts that side's blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | NUM_PH | High-side gate command per leg |
| lo_cmd | input | NUM_PH | Low-side gate command per leg |
| node_sense | input | NUM_PH | Digitised switch-node level per leg |
| win_len | input | WIN_W | Blanking window in clock cycles |
| hs_err | output | NUM_PH | High-side switching error per leg |
| ls_err | output | NUM_PH | Low-side switching error per leg |
| ph_err | output | NUM_PH | Per-leg error (either side) |
| any_err | output | 1 | Error on any leg |
| desat_hint | output | 1 | Any high-side error, for the desaturation flag |

## Verification
The bench builds the block with three legs and a 4-bit window (`WIN_W` = 4), so the on-time count saturates at 15. That small width lets a side held on for 40 cycles with `win_len` at 15 run past saturation in a short test. Random window lengths from 0 to 5 push many rising edges across the blanking boundary. They also give frequent short pulses that drop before the window ends.

// File: rtl/bfm_pkg.sv
// Package: shared side identifiers and the node level each side should produce.
// Assumes: the node comparator reads 1 when the switch node sits at the upper rail.
package bfm_pkg;
    typedef enum logic {SIDE_HI = 1'b0, SIDE_LO = 1'b1} side_e;

    // Level the node should settle to while the given side conducts alone.
    function automatic logic settled_level(side_e s);
        return (s == SIDE_HI);
    endfunction
endpackage

// File: rtl/bfm_blank_timer.sv
// Module: counts consecutive cycles a side command has been sampled on and
// opens the check once that count reaches the window length.
// Assumes: win_len may change at any time and takes effect at once.
module bfm_blank_timer #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_on,
    input  logic [WIN_W-1:0] win_len,
    output logic             check_open
);
    localparam logic [WIN_W-1:0] CNT_MAX = {WIN_W{1'b1}};

    logic [WIN_W-1:0] on_cnt;

    // Count previous consecutive on-samples, saturating; an off sample restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            on_cnt <= '0;
        else if (!cmd_on)
            on_cnt <= '0;
        else if (on_cnt != CNT_MAX)
            on_cnt <= on_cnt + 1'b1;
    end

    // Check is open once more than win_len on-samples are seen, this one included.
    always_comb check_open = (on_cnt >= win_len);
endmodule

// File: rtl/bfm_side_check.sv
// Module: checks one side of one leg; raises a registered error when this side
// conducts alone, its blanking window has passed, and the node disagrees.
// Assumes: node_sense is already synchronised to clk.
module bfm_side_check
    import bfm_pkg::*;
#(
    parameter int    WIN_W = 8,
    parameter side_e SIDE  = SIDE_HI
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             own_cmd,
    input  logic             other_cmd,
    input  logic             node_sense,
    input  logic [WIN_W-1:0] win_len,
    output logic             err
);
    localparam logic WANT = settled_level(SIDE);

    logic check_open;
    logic sole_on;
    logic mismatch;

    bfm_blank_timer #(.WIN_W(WIN_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_on     (own_cmd),
        .win_len    (win_len),
        .check_open (check_open)
    );

    // Qualify: this side alone, and the node differs from its settled level.
    always_comb begin
        sole_on  = own_cmd && !other_cmd;
        mismatch = node_sense ^ WANT;
    end

    // Register the gated mismatch as this side's error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else
            err <= sole_on && mismatch && check_open;
    end
endmodule

// File: rtl/bfm_phase.sv
// Module: one half-bridge leg, holding a high-side and a low-side checker and
// merging their errors.
// Assumes: commands are the logical gate states, after deadtime insertion.
module bfm_phase
    import bfm_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_cmd,
    input  logic             lo_cmd,
    input  logic             node_sense,
    input  logic [WIN_W-1:0] win_len,
    output logic             hs_err,
    output logic             ls_err,
    output logic             ph_err
);
    bfm_side_check #(.WIN_W(WIN_W), .SIDE(SIDE_HI)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_cmd    (hi_cmd),
        .other_cmd  (lo_cmd),
        .node_sense (node_sense),
        .win_len    (win_len),
        .err        (hs_err)
    );

    bfm_side_check #(.WIN_W(WIN_W), .SIDE(SIDE_LO)) u_ls (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_cmd    (lo_cmd),
        .other_cmd  (hi_cmd),
        .node_sense (node_sense),
        .win_len    (win_len),
        .err        (ls_err)
    );

    // Leg error is either side's error.
    always_comb ph_err = hs_err || ls_err;
endmodule

// File: rtl/bridge_fault_monitor.sv
// Module: top of the switching error detector; one leg checker per phase plus
// the any-leg and high-side summaries.
// Assumes: all inputs are synchronous to clk; win_len is shared by all legs.
module bridge_fault_monitor #(
    parameter int NUM_PH = 3,
    parameter int WIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] hi_cmd,
    input  logic [NUM_PH-1:0] lo_cmd,
    input  logic [NUM_PH-1:0] node_sense,
    input  logic [WIN_W-1:0]  win_len,
    output logic [NUM_PH-1:0] hs_err,
    output logic [NUM_PH-1:0] ls_err,
    output logic [NUM_PH-1:0] ph_err,
    output logic              any_err,
    output logic              desat_hint
);
    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        bfm_phase #(.WIN_W(WIN_W)) u_leg (
            .clk        (clk),
            .rst_n      (rst_n),
            .hi_cmd     (hi_cmd[p]),
            .lo_cmd     (lo_cmd[p]),
            .node_sense (node_sense[p]),
            .win_len    (win_len),
            .hs_err     (hs_err[p]),
            .ls_err     (ls_err[p]),
            .ph_err     (ph_err[p])
        );
    end

    // Summaries across legs.
    always_comb begin
        any_err    = |ph_err;
        desat_hint = |hs_err;
    end
endmodule

// File: rtl/bridge_fault_monitor_chk.sv
// Module: property checker for bridge_fault_monitor, attached with bind.
// Assumes: it observes only the top-level ports.
module bridge_fault_monitor_chk #(
    parameter int NUM_PH = 3,
    parameter int WIN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] hi_cmd,
    input logic [NUM_PH-1:0] lo_cmd,
    input logic [NUM_PH-1:0] node_sense,
    input logic [WIN_W-1:0]  win_len,
    input logic [NUM_PH-1:0] hs_err,
    input logic [NUM_PH-1:0] ls_err
);
    for (genvar p = 0; p < NUM_PH; p++) begin : g_prop
        AST_HS_SOLE_ON: assert property (@(posedge clk) disable iff (!rst_n)
            hs_err[p] |-> $past(hi_cmd[p] && !lo_cmd[p])); // R2
        AST_HS_NODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            hs_err[p] |-> !$past(node_sense[p])); // R2
        AST_LS_SOLE_ON: assert property (@(posedge clk) disable iff (!rst_n)
            ls_err[p] |-> $past(lo_cmd[p] && !hi_cmd[p])); // R3
        AST_LS_NODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ls_err[p] |-> $past(node_sense[p])); // R3
        AST_HS_BLANK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_cmd[p] && !$past(hi_cmd[p]) && win_len != '0) |=> !hs_err[p]); // R4
        AST_LS_BLANK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_cmd[p] && !$past(lo_cmd[p]) && win_len != '0) |=> !ls_err[p]); // R4
        AST_BOTH_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_cmd[p] && lo_cmd[p]) |=> (!hs_err[p] && !ls_err[p])); // R6
    end
endmodule

bind bridge_fault_monitor bridge_fault_monitor_chk #(.NUM_PH(NUM_PH), .WIN_W(WIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_cmd     (hi_cmd),
    .lo_cmd     (lo_cmd),
    .node_sense (node_sense),
    .win_len    (win_len),
    .hs_err     (hs_err),
    .ls_err     (ls_err)
);

// File: tb/bridge_fault_monitor_test.sv
module bridge_fault_monitor_test;
    localparam int NP  = 3;
    localparam int WW  = 4;
    localparam int MAX = (1 << WW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hi_cmd = '0, lo_cmd = '0, node_sense = '0;
    logic [WW-1:0] win_len = '0;
    logic [NP-1:0] hs_err, ls_err, ph_err;
    logic          any_err, desat_hint;

    int    n_checks = 0, n_err = 0;
    bit    done = 0;
    int    cnt_h[NP], cnt_l[NP];
    logic  exp_h[NP], exp_l[NP];
    string tag_h[NP], tag_l[NP];

    bridge_fault_monitor #(.NUM_PH(NP), .WIN_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .node_sense(node_sense), .win_len(win_len), .hs_err(hs_err),
        .ls_err(ls_err), .ph_err(ph_err), .any_err(any_err), .desat_hint(desat_hint)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Expected error for one side given the sampled inputs and prior on-count.
    function automatic logic side_err(logic own, logic oth, logic node, logic want, int cnt, int win);
        return own && !oth && (node != want) && (cnt >= win);
    endfunction

    function automatic string side_tag(string tag, logic own, logic oth, int cnt, int win, string base);
        if (tag != "") return tag;
        if (own == oth) return "R6";
        if (own && cnt < win) return "R4";
        return base;
    endfunction

    // Check outputs of the previous edge, then apply new inputs and predict.
    task automatic cycle(logic [NP-1:0] h, logic [NP-1:0] l, logic [NP-1:0] n, int win, string tag);
        logic any_e, des_e;
        @(negedge clk);
        any_e = 0; des_e = 0;
        for (int p = 0; p < NP; p++) begin
            chk(tag_h[p], hs_err[p], exp_h[p]);
            chk(tag_l[p], ls_err[p], exp_l[p]);
            chk("R7", ph_err[p], exp_h[p] | exp_l[p]);
            any_e |= exp_h[p] | exp_l[p];
            des_e |= exp_h[p];
        end
        chk("R7", any_err, any_e);
        chk("R8", desat_hint, des_e);
        hi_cmd = h; lo_cmd = l; node_sense = n; win_len = WW'(win);
        for (int p = 0; p < NP; p++) begin
            exp_h[p] = side_err(h[p], l[p], n[p], 1'b1, cnt_h[p], win);
            exp_l[p] = side_err(l[p], h[p], n[p], 1'b0, cnt_l[p], win);
            tag_h[p] = side_tag(tag, h[p], l[p], cnt_h[p], win, "R2");
            tag_l[p] = side_tag(tag, l[p], h[p], cnt_l[p], win, "R3");
            cnt_h[p] = h[p] ? ((cnt_h[p] < MAX) ? cnt_h[p] + 1 : MAX) : 0;
            cnt_l[p] = l[p] ? ((cnt_l[p] < MAX) ? cnt_l[p] + 1 : MAX) : 0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] h, l, n;
        int win;
        void'($urandom(32'h5eed_0017));
        for (int p = 0; p < NP; p++) begin
            cnt_h[p] = 0; cnt_l[p] = 0; exp_h[p] = 0; exp_l[p] = 0;
            tag_h[p] = "R1"; tag_l[p] = "R1";
        end
        // R1: outputs low while held in reset, with mismatching inputs applied.
        hi_cmd = '1; node_sense = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", |hs_err, 1'b0);
        chk("R1", |ls_err, 1'b0);
        chk("R1", any_err, 1'b0);
        hi_cmd = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cycle('0, '0, '0, 0, "R1");

        // R9: zero window checks from the first on-sample.
        cycle(3'b001, 3'b000, 3'b000, 0, "R9");
        cycle(3'b001, 3'b000, 3'b000, 0, "R9");
        cycle(3'b000, 3'b010, 3'b010, 0, "R9");
        cycle(3'b000, 3'b000, 3'b000, 0, "R9");
        // R5: command dropped before a 4-cycle window ends.
        for (int k = 0; k < 3; k++) cycle(3'b100, 3'b000, 3'b000, 4, "R5");
        cycle(3'b000, 3'b000, 3'b000, 4, "R5");
        for (int k = 0; k < 4; k++) cycle(3'b000, 3'b100, 3'b100, 4, "R5");
        cycle(3'b000, 3'b000, 3'b000, 4, "R5");
        // R11: error after the window, a short gap, then blanking starts over.
        for (int k = 0; k < 6; k++) cycle(3'b010, 3'b000, 3'b000, 3, "R11");
        cycle(3'b000, 3'b000, 3'b000, 3, "R11");
        for (int k = 0; k < 6; k++) cycle(3'b010, 3'b000, 3'b000, 3, "R11");
        // R6: both sides on with the node low, then both off.
        for (int k = 0; k < 6; k++) cycle(3'b111, 3'b111, 3'b000, 0, "R6");
        for (int k = 0; k < 3; k++) cycle(3'b000, 3'b000, 3'b111, 0, "R6");
        // R10: maximum window, held past count saturation.
        for (int k = 0; k < 40; k++) cycle(3'b001, 3'b000, 3'b000, MAX, "R10");
        for (int k = 0; k < 40; k++) cycle(3'b000, 3'b001, 3'b001, MAX, "R10");

        // Random segments with varying windows.
        h = '0; l = '0; win = 2;
        for (int c = 0; c < 3000; c++) begin
            if (c % 150 == 0) win = $urandom_range(0, 5);
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 5) == 0) begin
                    case ($urandom_range(0, 9))
                        0:       begin h[p] = 1; l[p] = 1; end
                        1:       begin h[p] = 0; l[p] = 0; end
                        2,3,4,5: begin h[p] = 1; l[p] = 0; end
                        default: begin h[p] = 0; l[p] = 1; end
                    endcase
                end
                n[p] = ($urandom_range(0, 3) == 0) ? ~h[p] : h[p];
            end
            cycle(h, l, n, win, "");
        end
        cycle('0, '0, '0, 0, "");
        cycle('0, '0, '0, 0, "");
        done = 1;
        summary();
        $finish;
    end
endmodule